// File: doc/BRIEF.md
# Streaming Matrix Multiplier with Operand Caches

The block forms the product of two 3x3 signed integer matrices, R = A x B. All three matrices move through streaming ports with a valid/ready handshake, so every operand is consumed and every result produced strictly in order, with no addressing. An A beat carries one whole row and a B beat carries one whole column. Each A row is fetched once and held while its three results are formed. Each B column is fetched once, during the first output row, and kept in a local buffer that serves output rows 1 and 2.

Each result is a fresh dot product of the held A row and the selected B column. Results leave row-major, one 16-bit word per beat, with a flag on the ninth word. When no stream stalls, the block issues one result per clock, so a call takes nine cycles. The row and column counters wrap to zero after the ninth result, so the next call starts on the following cycle. A stall on any stream freezes the sequence without losing or repeating data.

Top module: `stream_matmul`

## Requirements
- R1: A synchronous active-low reset clears the result valid and returns the sequencer to row 0, column 0. This includes a reset in the middle of a call.
- R2: An A beat is accepted only when the result being issued is in column 0, so each call takes exactly 3 A beats. By the time the result at row-major index k of a call appears, floor(k/3)+1 A beats of that call have been taken. An A word holds element (r,c) at bits [8c+7:8c].
- R3: B beats are accepted only during output row 0, so each call takes exactly 3 B beats. Rows 1 and 2 read the buffered columns, and B data waiting for the next call is left untouched. A B word holds element (k,j) of column j at bits [8k+7:8k].
- R4: Each result is the sum over k of A(i,k)*B(k,j), with signed 8-bit operands, reduced to 16 bits in two's complement (wrapping).
- R5: The results of a call appear in row-major order, (0,0), (0,1), ..., (2,2), nine per call.
- R6: The last flag is high on the ninth result of every call and low on the other eight.
- R7: While the result is valid and not ready, the result valid, data and last flag hold steady.
- R8: While the result is valid and not ready, neither input stream is accepted.
- R9: No operand is accepted and no result is produced while a stream that the current step needs is empty.
- R10: With no stalls, consecutive calls run back to back at one result per clock, so call n+1 starts nine cycles after call n.
- R11: A result becomes valid on the clock after the edge that accepted its operands, or issued it from the caches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_valid | input | 1 | A row word is present |
| a_ready | output | 1 | A row word is taken at this edge |
| a_data | input | 24 | One row of A, three signed bytes |
| b_valid | input | 1 | B column word is present |
| b_ready | output | 1 | B column word is taken at this edge |
| b_data | input | 24 | One column of B, three signed bytes |
| r_valid | output | 1 | Result word is present |
| r_ready | input | 1 | Consumer takes the result at this edge |
| r_data | output | 16 | Signed result element |
| r_last | output | 1 | Marks the ninth result of a call |

## Verification
The bench keeps the next call's A and B words waiting on the inputs while the current call runs. A design that fetched a B column again in rows 1 or 2, or an A row again in columns 1 or 2, would consume the next call's data, and the counts of words taken at each result would expose it. Operands of -128 push the sum past the 16-bit range, to catch a design that saturates or widens wrongly. Stall patterns on each stream are staggered so that back-pressure, empty inputs and issue from the caches overlap. A design that dropped, repeated or changed a held result would produce a wrong value or a wrong count. A reset in the middle of a call must return the block to row 0, and an unstalled run must place result k exactly k+1 cycles after the first beat.

// File: rtl/mm_pkg.sv
// Package: shared defaults and helpers for the streaming matrix multiplier.
// Assumes: square matrices, signed operands, two's-complement wrapping sums.
package mm_pkg;
    localparam int unsigned MM_DIM_DEF   = 3;
    localparam int unsigned MM_EL_W_DEF  = 8;
    localparam int unsigned MM_RES_W_DEF = 16;

    // Width of an index that counts 0..n-1 (at least one bit).
    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/mm_seq.sv
// Module: row/column sequencer. Advances one position per issued result in
// row-major order and wraps to (0,0) after the final element.
// Assumes: adv is asserted only on a cycle that issues a result.
module mm_seq #(
    parameter int unsigned DIM = 3,
    localparam int unsigned IW = mm_pkg::idx_w(DIM)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [IW-1:0] row,
    output logic [IW-1:0] col,
    output logic          at_col0,
    output logic          at_row0,
    output logic          at_end
);
    localparam logic [IW-1:0] LAST_IDX = IW'(DIM - 1);

    assign at_col0 = (col == '0);
    assign at_row0 = (row == '0);
    assign at_end  = (row == LAST_IDX) && (col == LAST_IDX);

    // Step the position counters on each issued result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row <= '0;
            col <= '0;
        end else if (adv) begin
            if (col == LAST_IDX) begin
                col <= '0;
                row <= (row == LAST_IDX) ? '0 : row + 1'b1;
            end else begin
                col <= col + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mm_cache.sv
// Module: operand caches. Holds the current A row and every B column seen
// during row 0. Presents either the live stream word (on a loading step)
// or the cached copy to the datapath.
// Assumes: a live word is only selected on the step that also loads it.
module mm_cache #(
    parameter int unsigned DIM  = 3,
    parameter int unsigned EL_W = 8,
    localparam int unsigned IW  = mm_pkg::idx_w(DIM),
    localparam int unsigned VW  = DIM * EL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_live,
    input  logic          a_load,
    input  logic [VW-1:0] a_word,
    input  logic          b_live,
    input  logic          b_load,
    input  logic [VW-1:0] b_word,
    input  logic [IW-1:0] col,
    output logic [VW-1:0] a_use,
    output logic [VW-1:0] b_use
);
    logic [VW-1:0] a_hold;
    logic [VW-1:0] b_hold [DIM];

    // Capture the A row when it is taken from the stream.
    always_ff @(posedge clk) begin
        if (!rst_n)      a_hold <= '0;
        else if (a_load) a_hold <= a_word;
    end

    for (genvar j = 0; j < DIM; j++) begin : g_bcol
        // Capture column j of B when it is taken during row 0.
        always_ff @(posedge clk) begin
            if (!rst_n)                           b_hold[j] <= '0;
            else if (b_load && (col == IW'(j)))   b_hold[j] <= b_word;
        end
    end

    // Choose live or cached operands for this step.
    always_comb begin
        a_use = a_live ? a_word : a_hold;
        b_use = b_live ? b_word : b_hold[col];
    end
endmodule

// File: rtl/mm_dot.sv
// Module: combinational dot product of two packed signed vectors.
// Assumes: the result wraps in RES_W bits (two's complement).
module mm_dot #(
    parameter int unsigned DIM   = 3,
    parameter int unsigned EL_W  = 8,
    parameter int unsigned RES_W = 16,
    localparam int unsigned VW   = DIM * EL_W,
    localparam int unsigned PW   = 2 * EL_W
) (
    input  logic [VW-1:0]    x,
    input  logic [VW-1:0]    y,
    output logic [RES_W-1:0] dot
);
    logic signed [PW-1:0] prod [DIM];

    for (genvar k = 0; k < DIM; k++) begin : g_mul
        assign prod[k] = PW'($signed(x[k*EL_W +: EL_W])) * PW'($signed(y[k*EL_W +: EL_W]));
    end

    // Sum the products with sign extension into the result width.
    always_comb begin
        logic signed [RES_W-1:0] acc;
        acc = '0;
        for (int k = 0; k < DIM; k++) acc = acc + RES_W'(prod[k]);
        dot = acc;
    end
endmodule

// File: rtl/stream_matmul.sv
// Module: streaming matrix multiplier. Issues one result per step in
// row-major order. A step in column 0 needs an A word, and a step in row 0
// needs a B word. A step fires when its inputs are present and the output
// register is free or draining. Results sit in one output register.
// Assumes: A words carry rows, B words carry columns, little-end element first.
module stream_matmul #(
    parameter int unsigned DIM   = mm_pkg::MM_DIM_DEF,
    parameter int unsigned EL_W  = mm_pkg::MM_EL_W_DEF,
    parameter int unsigned RES_W = mm_pkg::MM_RES_W_DEF,
    localparam int unsigned VW   = DIM * EL_W,
    localparam int unsigned IW   = mm_pkg::idx_w(DIM)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_valid,
    output logic             a_ready,
    input  logic [VW-1:0]    a_data,
    input  logic             b_valid,
    output logic             b_ready,
    input  logic [VW-1:0]    b_data,
    output logic             r_valid,
    input  logic             r_ready,
    output logic [RES_W-1:0] r_data,
    output logic             r_last
);
    logic [IW-1:0]    row, col;
    logic             at_col0, at_row0, at_end;
    logic             out_free, fire;
    logic [VW-1:0]    a_use, b_use;
    logic [RES_W-1:0] dot;

    // Decide whether this step can issue and which streams it consumes.
    always_comb begin
        out_free = !r_valid || r_ready;
        fire     = out_free && (!at_col0 || a_valid) && (!at_row0 || b_valid);
        a_ready  = fire && at_col0;
        b_ready  = fire && at_row0;
    end

    mm_seq #(.DIM(DIM)) u_seq (
        .clk(clk), .rst_n(rst_n), .adv(fire),
        .row(row), .col(col),
        .at_col0(at_col0), .at_row0(at_row0), .at_end(at_end)
    );

    mm_cache #(.DIM(DIM), .EL_W(EL_W)) u_cache (
        .clk(clk), .rst_n(rst_n),
        .a_live(at_col0), .a_load(a_ready), .a_word(a_data),
        .b_live(at_row0), .b_load(b_ready), .b_word(b_data),
        .col(col), .a_use(a_use), .b_use(b_use)
    );

    mm_dot #(.DIM(DIM), .EL_W(EL_W), .RES_W(RES_W)) u_dot (
        .x(a_use), .y(b_use), .dot(dot)
    );

    // Output register: load on issue, clear when drained.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_valid <= 1'b0;
            r_data  <= '0;
            r_last  <= 1'b0;
        end else if (fire) begin
            r_valid <= 1'b1;
            r_data  <= dot;
            r_last  <= at_end;
        end else if (r_ready) begin
            r_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/mm_chk.sv
// Module: protocol and ordering checker bound to stream_matmul.
// Assumes: observes ports only; keeps its own count of drained results.
module mm_chk #(
    parameter int unsigned DIM   = 3,
    parameter int unsigned RES_W = 16,
    localparam int unsigned CW   = mm_pkg::idx_w(DIM * DIM)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             a_valid,
    input logic             a_ready,
    input logic             b_valid,
    input logic             b_ready,
    input logic             r_valid,
    input logic             r_ready,
    input logic [RES_W-1:0] r_data,
    input logic             r_last
);
    localparam logic [CW-1:0] END_CNT = CW'(DIM * DIM - 1);
    logic [CW-1:0] out_cnt;

    // Count results handed to the consumer within the current call.
    always_ff @(posedge clk) begin
        if (!rst_n)                  out_cnt <= '0;
        else if (r_valid && r_ready) out_cnt <= (out_cnt == END_CNT) ? '0 : out_cnt + 1'b1;
    end

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !r_valid); // R1
    AST_LAST_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid && r_ready) |-> (r_last == (out_cnt == END_CNT))); // R6
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid && !r_ready) |=> (r_valid && $stable(r_data) && $stable(r_last))); // R7
    AST_NO_TAKE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid && !r_ready) |-> (!a_ready && !b_ready)); // R8
    AST_A_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        a_ready |-> a_valid); // R9
    AST_B_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        b_ready |-> b_valid); // R9
endmodule

bind stream_matmul mm_chk #(.DIM(DIM), .RES_W(RES_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .a_valid(a_valid), .a_ready(a_ready),
    .b_valid(b_valid), .b_ready(b_ready),
    .r_valid(r_valid), .r_ready(r_ready),
    .r_data(r_data), .r_last(r_last)
);

// File: tb/sim_stream_matmul.sv
// Bench: a table of operand pairs with stall patterns, walked by one loop,
// then directed reset and empty-stream tests.
module sim_stream_matmul;
    localparam int CLK_PERIOD = 10;
    localparam int NCASE = 4;

    // Element (r,c) of a matrix at bits [(3r+c)*8 +: 8].
    localparam logic [71:0] A_TAB [NCASE] = '{
        72'h09_08_07_06_05_04_03_02_01,
        72'h80_80_80_80_80_80_80_80_80,
        72'h7F_81_00_FF_02_FE_10_F0_33,
        72'h01_00_00_00_01_00_00_00_01
    };
    localparam logic [71:0] B_TAB [NCASE] = '{
        72'hFF_FE_FD_03_02_01_01_00_00,
        72'h80_80_80_80_80_80_80_80_80,
        72'h7F_7F_7F_80_80_80_C3_5A_11,
        72'h21_E5_44_9C_07_31_F2_0D_6E
    };
    localparam int A_MOD [NCASE] = '{0, 3, 0, 2};
    localparam int B_MOD [NCASE] = '{0, 0, 4, 3};
    localparam int R_MOD [NCASE] = '{0, 2, 3, 5};

    logic        clk = 1'b0;
    logic        rst_n;
    logic        a_valid, a_ready, b_valid, b_ready;
    logic [23:0] a_data, b_data;
    logic        r_valid, r_ready, r_last;
    logic [15:0] r_data;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stream_matmul u0 (
        .clk(clk), .rst_n(rst_n),
        .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data),
        .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data),
        .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_last(r_last)
    );

    function automatic logic [23:0] row_of(input logic [71:0] m, input int r);
        return m[r*24 +: 24];
    endfunction

    function automatic logic [23:0] col_of(input logic [71:0] m, input int j);
        logic [23:0] w;
        for (int k = 0; k < 3; k++) w[k*8 +: 8] = m[(k*3+j)*8 +: 8];
        return w;
    endfunction

    function automatic logic [15:0] expect_at(input logic [71:0] a, input logic [71:0] b,
                                              input int i, input int j);
        int s;
        logic [7:0] x, y;
        s = 0;
        for (int k = 0; k < 3; k++) begin
            x = a[(i*3+k)*8 +: 8];
            y = b[(k*3+j)*8 +: 8];
            s = s + $signed(x) * $signed(y);
        end
        return s[15:0];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Run ncalls back-to-back calls starting at table case c0, with stall moduli.
    task automatic run_calls(input int c0, input int ncalls, input int am, input int bm,
                             input int rm, input bit timed);
        int ai = 0, bi = 0, ri = 0, cyc = 0;
        bit hold = 1'b0;
        logic [15:0] held = '0;
        while (ri < 9*ncalls && cyc < 3000) begin
            @(negedge clk);
            a_valid = (ai < 3*ncalls) && !(am > 0 && (cyc % am) == 1);
            a_data  = row_of(A_TAB[(c0 + ai/3) % NCASE], ai % 3);
            b_valid = (bi < 3*ncalls) && !(bm > 0 && (cyc % bm) == 1);
            b_data  = col_of(B_TAB[(c0 + bi/3) % NCASE], bi % 3);
            r_ready = !(rm > 0 && (cyc % rm) == 1);
            #1;
            if (r_valid) begin
                if (hold) chk(r_data == held, "R7 held data", 32'(r_data), 32'(held));
                if (!r_ready) chk(!a_ready && !b_ready, "R8 take while blocked",
                                  {30'd0, a_ready, b_ready}, 32'd0);
                if (r_ready) begin
                    int c, k;
                    logic [15:0] ev;
                    c = ri / 9;
                    k = ri % 9;
                    ev = expect_at(A_TAB[(c0+c) % NCASE], B_TAB[(c0+c) % NCASE], k/3, k%3);
                    chk(r_data == ev, "R4 R5 result value", 32'(r_data), 32'(ev));
                    chk(r_last == (k == 8), "R6 last flag", 32'(r_last), 32'(k == 8));
                    chk(ai == 3*c + k/3 + 1, "R2 A words taken", 32'(ai), 32'(3*c + k/3 + 1));
                    chk(bi == 3*c + ((k < 3) ? k + 1 : 3), "R3 B words taken",
                        32'(bi), 32'(3*c + ((k < 3) ? k + 1 : 3)));
                    if (timed) chk(cyc == ri + 1, "R10 R11 result cycle", 32'(cyc), 32'(ri + 1));
                    ri++;
                end
                hold = !r_ready;
                held = r_data;
            end else begin
                hold = 1'b0;
            end
            if (a_valid && a_ready) ai++;
            if (b_valid && b_ready) bi++;
            cyc++;
        end
        chk(ri == 9*ncalls, "R5 result count", 32'(ri), 32'(9*ncalls));
        @(negedge clk);
        a_valid = 1'b0;
        b_valid = 1'b0;
        r_ready = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; a_valid = 1'b0; b_valid = 1'b0; r_ready = 1'b1;
        a_data = '0; b_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!r_valid, "R1 reset idle", 32'(r_valid), 32'd0);

        // Table walk: each entry runs two back-to-back calls.
        for (int t = 0; t < NCASE; t++)
            run_calls(t, 2, A_MOD[t], B_MOD[t], R_MOD[t], (A_MOD[t] == 0 && B_MOD[t] == 0 && R_MOD[t] == 0));

        // R9: A missing at a column-0 step blocks everything.
        @(negedge clk);
        b_valid = 1'b1; b_data = 24'h010203; a_valid = 1'b0;
        repeat (4) begin
            @(negedge clk); #1;
            chk(!r_valid && !b_ready, "R9 A empty stalls", {30'd0, r_valid, b_ready}, 32'd0);
        end
        // R9: B missing at a row-0 step blocks everything.
        b_valid = 1'b0; a_valid = 1'b1; a_data = 24'h040506;
        repeat (4) begin
            @(negedge clk); #1;
            chk(!r_valid && !a_ready, "R9 B empty stalls", {30'd0, r_valid, a_ready}, 32'd0);
        end

        // R1: reset in the middle of a call, then a clean call from row 0.
        a_data = row_of(A_TAB[2], 0); b_valid = 1'b1; b_data = col_of(B_TAB[2], 0);
        @(negedge clk);
        a_valid = 1'b0; b_data = col_of(B_TAB[2], 1);
        @(negedge clk);
        rst_n = 1'b0; b_valid = 1'b0;
        @(negedge clk); #1;
        chk(!r_valid, "R1 mid-call reset clears output", 32'(r_valid), 32'd0);
        rst_n = 1'b1;
        run_calls(1, 1, 0, 0, 0, 1'b1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule